// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Array

This block multiplies a stream of activation vectors by a weight matrix held inside a square grid of N x N multiply-accumulate cells. Every cell keeps one signed 8-bit weight. Activations move one cell to the right per cycle. Signed 32-bit partial sums start at zero at the top edge and move one cell down per cycle. Each cell adds the product of its weight and the passing activation to the partial sum. Only the finished column sums leave the grid, at the bottom edge.

Weights enter through a per-column shift path at the top of the grid. While the load enable is high, every column shifts its weights down by one row. Input rows are skewed and output columns are de-skewed inside the block. A caller therefore presents a whole activation vector in one cycle, and a whole result vector comes back in one cycle with a single valid pulse. One new vector can be accepted on every clock cycle.

Top module: `sa_top`

## Requirements
- R1: For each accepted activation vector x, output column j carries the sum over rows i of x[i]*W[i][j]. All operands are signed two's complement and the sum is kept in 32 bits. Row i of `act_in` is bits [8i+7:8i], and column j of `res_out` is bits [32j+31:32j].
- R2: If a vector is accepted at rising edge E, `res_valid` is high and all N columns of its result are present after edge E+2N-2. The result is held for exactly one cycle, and every column belongs to the same input vector.
- R3: Vectors presented on consecutive cycles give results on consecutive cycles, in the same order.
- R4: Each edge with `wload_en` high shifts every column down by one row, and row 0 of column j takes bits [8j+7:8j] of `wload_col`. After N load edges, the value presented at load edge k (counting from 0) sits in row N-1-k.
- R5: Weights do not change while `wload_en` is low. A reset leaves them unchanged.
- R6: `act_valid` is ignored on any edge where `wload_en` is high. Such a vector never produces a result.
- R7: A synchronous active-high `rst` clears all pipeline state. After a reset edge, `res_valid` is 0 and `res_out` is 0. Vectors that were in flight before the reset never appear.
- R8: In a cycle where `res_valid` is low, `res_out` is all zero, whatever data was presented with `act_valid` low.
- R9: Extreme operands (-128 and 127 in weights and activations) produce exact signed results. One example is N*16384 when every operand is -128.
- R10: A partial load of fewer than N edges shifts the existing weights down by that many rows. Weights pushed past the bottom row are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline (not the weights) |
| wload_en | input | 1 | Shift the weight columns down one row on this edge |
| wload_col | input | 8*N | Weight entering row 0 of each column, column j at [8j+7:8j] |
| act_in | input | 8*N | Activation vector, row i at [8i+7:8i] |
| act_valid | input | 1 | act_in holds a vector to process |
| res_out | output | 32*N | Result vector, column j at [32j+31:32j] |
| res_valid | output | 1 | res_out holds a completed result vector |

## Verification
The assertions assume that weights are reloaded only while the grid holds no valid wavefront. Otherwise a vector in flight would meet a mix of old and new weights, and no fixed matrix describes its result. To stay inside that assumption, the stimulus idles for more than 2N-1 cycles before every load sequence, and before every reset that is not meant to discard data. The one deliberate reset with vectors in flight is checked only for the absence of their results. Activations that are presented with the valid flag low, or during a load, carry non-zero patterns. This checks that gating happens at the grid input and not by chance.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int ACT_W = 8;
  localparam int SUM_W = 32;
  localparam int PRD_W = 2 * ACT_W;

  // one multiply-accumulate step of a cell, wrapping in SUM_W bits
  function automatic logic signed [SUM_W-1:0] mac_step(
    input logic signed [SUM_W-1:0] psum,
    input logic signed [ACT_W-1:0] act,
    input logic signed [ACT_W-1:0] wgt
  );
    logic signed [PRD_W-1:0] prod;
    prod = act * wgt;
    return psum + SUM_W'(prod);
  endfunction
endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (D == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] st [D];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < D; k++) st[k] <= '0;
        end else begin
          st[0] <= din;
          for (int k = 1; k < D; k++) st[k] <= st[k-1];
        end
      end
      assign dout = st[D-1];
    end
  endgenerate
endmodule

// File: rtl/sa_pe.sv
module sa_pe
  import sa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wshift,
  input  logic        [ACT_W-1:0] w_in,
  output logic        [ACT_W-1:0] w_out,
  input  logic signed [ACT_W-1:0] a_in,
  input  logic                    v_in,
  input  logic signed [SUM_W-1:0] s_in,
  output logic signed [ACT_W-1:0] a_out,
  output logic                    v_out,
  output logic signed [SUM_W-1:0] s_out
);
  logic [ACT_W-1:0] w_q;

  // weight register: shifted only on load, untouched by reset
  always_ff @(posedge clk) begin
    if (wshift) w_q <= w_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      v_out <= 1'b0;
      s_out <= '0;
    end else begin
      a_out <= a_in;
      v_out <= v_in;
      s_out <= v_in ? mac_step(s_in, a_in, $signed(w_q)) : s_in;
    end
  end

  assign w_out = w_q;
endmodule

// File: rtl/sa_top.sv
module sa_top
  import sa_pkg::*;
#(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wload_en,
  input  logic [N*ACT_W-1:0] wload_col,
  input  logic [N*ACT_W-1:0] act_in,
  input  logic               act_valid,
  output logic [N*SUM_W-1:0] res_out,
  output logic               res_valid
);
  localparam int LAT = 2 * N - 1;

  logic signed [ACT_W-1:0] a_h [N][N+1];
  logic                    v_h [N][N+1];
  logic signed [SUM_W-1:0] s_v [N+1][N];
  logic        [ACT_W-1:0] w_v [N+1][N];

  // named internal events for the checker
  logic                     accept;
  logic [N-1:0]             col_vld;
  logic [N-1:0]             v_exit;
  logic [N*ACT_W-1:0]       a_exit;
  logic [N*N*ACT_W-1:0]     wgt_all;

  assign accept = act_valid & ~wload_en;

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [ACT_W-1:0] a_gated;
    assign a_gated = act_in[i*ACT_W +: ACT_W] & {ACT_W{accept}};

    sa_delay #(.W(ACT_W + 1), .D(i)) u_skew (
      .clk (clk),
      .rst (rst),
      .din ({accept, a_gated}),
      .dout({v_h[i][0], a_h[i][0]})
    );

    for (genvar j = 0; j < N; j++) begin : g_col
      sa_pe u_pe (
        .clk   (clk),
        .rst   (rst),
        .wshift(wload_en),
        .w_in  (w_v[i][j]),
        .w_out (w_v[i+1][j]),
        .a_in  (a_h[i][j]),
        .v_in  (v_h[i][j]),
        .s_in  (s_v[i][j]),
        .a_out (a_h[i][j+1]),
        .v_out (v_h[i][j+1]),
        .s_out (s_v[i+1][j])
      );
      assign wgt_all[(i*N+j)*ACT_W +: ACT_W] = w_v[i+1][j];
    end

    assign v_exit[i]                 = v_h[i][N];
    assign a_exit[i*ACT_W +: ACT_W]  = a_h[i][N];
  end

  for (genvar j = 0; j < N; j++) begin : g_edge
    assign s_v[0][j] = '0;
    assign w_v[0][j] = wload_col[j*ACT_W +: ACT_W];

    sa_delay #(.W(SUM_W + 1), .D(N - 1 - j)) u_deskew (
      .clk (clk),
      .rst (rst),
      .din ({v_h[N-1][j+1], s_v[N][j]}),
      .dout({col_vld[j], res_out[j*SUM_W +: SUM_W]})
    );
  end

  assign res_valid = col_vld[N-1];
endmodule

// File: rtl/sa_chk.sv
module sa_chk
  import sa_pkg::*;
#(
  parameter int N = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wload_en,
  input logic                   act_valid,
  input logic                   res_valid,
  input logic [N*SUM_W-1:0]     res_out,
  input logic [N-1:0]           col_vld,
  input logic [N-1:0]           v_exit,
  input logic [N*ACT_W-1:0]     a_exit,
  input logic [N*N*ACT_W-1:0]   wgt_all
);
  localparam int LAT = 2 * N - 1;

  logic [LAT-1:0] acc_pipe;
  always_ff @(posedge clk) begin
    if (rst) acc_pipe <= '0;
    else     acc_pipe <= (acc_pipe << 1) | LAT'(act_valid & ~wload_en);
  end

  // R7
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!res_valid && res_out == '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst) !res_valid |-> res_out == '0);

  // R2
  lat_align_chk: assert property (@(posedge clk) disable iff (rst) res_valid == acc_pipe[LAT-1]);

  // R2
  col_align_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(col_vld) == 0) || ($countones(col_vld) == N));

  // R5
  wgt_hold_chk: assert property (@(posedge clk) disable iff (rst) !wload_en |=> $stable(wgt_all));

  for (genvar r = 0; r < N; r++) begin : g_row
    // R8
    bubble_act_chk: assert property (@(posedge clk) disable iff (rst)
      !v_exit[r] |-> a_exit[r*ACT_W +: ACT_W] == '0);
  end
endmodule

bind sa_top sa_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wload_en (wload_en),
  .act_valid(act_valid),
  .res_valid(res_valid),
  .res_out  (res_out),
  .col_vld  (col_vld),
  .v_exit   (v_exit),
  .a_exit   (a_exit),
  .wgt_all  (wgt_all)
);

// File: tb/tb_sa_top.sv
`timescale 1ns/1ps
module tb_sa_top;
  localparam int N   = 4;
  localparam int LAT = 2 * N - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wload_en = 1'b0;
  logic [N*8-1:0]  wload_col = '0;
  logic [N*8-1:0]  act_in = '0;
  logic            act_valid = 1'b0;
  logic [N*32-1:0] res_out;
  logic            res_valid;

  sa_top #(.N(N)) dut (
    .clk(clk), .rst(rst), .wload_en(wload_en), .wload_col(wload_col),
    .act_in(act_in), .act_valid(act_valid), .res_out(res_out), .res_valid(res_valid)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef logic signed [7:0] mat_t [N][N];
  mat_t wm;

  logic [N*32-1:0] exp_q[$];
  int              due_q[$];
  string           tag_q[$];

  // stimulus table: bit 32 = valid, row i at [8i+7:8i]
  localparam logic [32:0] STIM [12] = '{
    {1'b1, 32'h04_03_02_01},
    {1'b1, 32'hFF_FF_FF_FF},
    {1'b0, 32'h5A_A5_5A_A5},
    {1'b1, 32'h80_7F_80_7F},
    {1'b1, 32'h00_00_00_00},
    {1'b1, 32'h10_F0_20_E0},
    {1'b0, 32'h33_CC_33_CC},
    {1'b0, 32'h01_01_01_01},
    {1'b1, 32'h7F_7F_7F_7F},
    {1'b1, 32'h01_00_00_00},
    {1'b1, 32'h00_00_00_01},
    {1'b1, 32'hC3_3C_96_69}
  };

  task automatic fail(string tag, logic [N*32-1:0] got, logic [N*32-1:0] exp);
    n_bad++;
    $display("FAIL %s: got %h expected %h", tag, got, exp);
  endtask

  function automatic logic [N*32-1:0] model(logic [N*8-1:0] a);
    logic [N*32-1:0] r;
    for (int j = 0; j < N; j++) begin
      int acc = 0;
      for (int i = 0; i < N; i++) begin
        int x = int'($signed(a[i*8 +: 8]));
        int w = int'(wm[i][j]);
        acc += x * w;
      end
      r[j*32 +: 32] = acc;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          n_chk++;
          fail("R6/R7 unexpected result", res_out, '0);
        end else begin
          logic [N*32-1:0] e;
          int d;
          string t;
          e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
          n_chk++;
          if (res_out !== e) fail(t, res_out, e);
          n_chk++;
          if (cyc != d) fail("R2 latency", cyc, d);
        end
      end else begin
        n_chk++;
        if (res_out !== '0) fail("R8 idle output", res_out, '0);
        if (due_q.size() > 0 && cyc > due_q[0]) begin
          n_chk++;
          fail("R2/R3 missing result", exp_q[0], '0);
          void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
      end
    end
  end

  task automatic drive(logic v, logic [N*8-1:0] a, string tag);
    @(negedge clk);
    act_valid = v;
    act_in    = a;
    if (v && !wload_en) begin
      exp_q.push_back(model(a));
      due_q.push_back(cyc + 1 + 2*N - 2);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(1'b0, 32'hA5_5A_C3_3C, "");
  endtask

  // one load edge; act_valid is held high to show it is ignored (R6)
  task automatic load_col(logic [N*8-1:0] col);
    @(negedge clk);
    wload_en  = 1'b1;
    wload_col = col;
    act_valid = 1'b1;
    act_in    = 32'h11_22_33_44;
    for (int j = 0; j < N; j++) begin
      for (int i = N - 1; i > 0; i--) wm[i][j] = wm[i-1][j];
      wm[0][j] = col[j*8 +: 8];
    end
  endtask

  task automatic end_load();
    @(negedge clk);
    wload_en  = 1'b0;
    act_valid = 1'b0;
  endtask

  task automatic load_matrix(mat_t m);
    for (int k = 0; k < N; k++) begin
      logic [N*8-1:0] col;
      for (int j = 0; j < N; j++) col[j*8 +: 8] = m[N-1-k][j];
      load_col(col);
    end
    end_load();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    mat_t m1, mx;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        wm[i][j] = '0;
        m1[i][j] = 8'(i*37 - j*53 + 11);
        mx[i][j] = -8'sd128;
      end

    // R7: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0 || res_out !== '0) fail("R7 reset state", res_out, '0);
    rst = 1'b0;
    mon_on = 1'b1;

    // R4/R6: full load with act_valid held high
    load_matrix(m1);
    idle(2);

    // R1/R3/R8: table walk, back to back with bubbles
    for (int k = 0; k < 12; k++) drive(STIM[k][32], STIM[k][31:0], "R1/R3 table");
    idle(LAT + 3);

    // R5: weights survive reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    drive(1'b1, 32'h04_03_02_01, "R5 after reset");
    drive(1'b1, 32'hF9_07_E2_1D, "R5 after reset");
    idle(LAT + 3);

    // R10: partial load of two edges
    load_col(32'h05_FB_7F_80);
    load_col(32'h81_02_FE_03);
    end_load();
    drive(1'b1, 32'h01_01_01_01, "R10 partial load");
    drive(1'b1, 32'h80_01_7F_FF, "R10 partial load");
    idle(LAT + 3);

    // R9: extremes
    load_matrix(mx);
    drive(1'b1, 32'h80_80_80_80, "R9 all -128");
    drive(1'b1, 32'h7F_7F_7F_7F, "R9 127 x -128");
    idle(LAT + 3);
    n_chk++;
    if (exp_q.size() != 0) fail("R9 results outstanding", exp_q.size(), 0);

    // R7: reset discards vectors in flight
    drive(1'b1, 32'h01_02_03_04, "R7 flushed");
    drive(1'b1, 32'h05_06_07_08, "R7 flushed");
    @(negedge clk);
    mon_on = 1'b0;
    act_valid = 1'b0;
    rst = 1'b1;
    exp_q.delete(); due_q.delete(); tag_q.delete();
    @(negedge clk);
    rst = 1'b0;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 2*LAT; k++) begin
        @(negedge clk);
        if (res_valid) seen = 1'b1;
      end
      n_chk++;
      if (seen) fail("R7 flushed vector appeared", 1, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule